// File: doc/BRIEF.md
# Clock-Line Reset Pattern Detector

This block stands in for a dedicated reset pin on a serial-controlled converter. It watches the serial clock line while chip-select is held low, measures the length of every high and low level in master-clock cycles, and issues a single-cycle internal reset pulse when it recognises three long high pulses. The pulses must have increasing, non-overlapping lengths and be separated by short lows. The three windows are far longer than any level seen during ordinary serial transfers, so normal traffic cannot trigger it.

The serial clock is brought into the master-clock domain through a two-stage synchronizer. A run-length counter then measures each level, saturating just above the longest accepted length. A small phase sequencer compares the length of each completed level against its window. A level outside its window returns the sequencer to idle. A high level that fails as the second or third pulse but fits the first window starts a new attempt. What the pulse clears is decided elsewhere.

Top module: `rstpat_detect`

## Requirements
- R1: A high level is accepted as the first pulse only if its synchronized length is between 512 and 800 master-clock cycles inclusive; 511 or 801 cycles is rejected.
- R2: Each low level between accepted high pulses must last at least 10 master-clock cycles; a low of 9 cycles returns the detector to idle.
- R3: The second high pulse is accepted only with a length between 1024 and 1800 cycles inclusive.
- R4: The third high pulse is accepted only with a length between 2048 and 2400 cycles inclusive.
- R5: `reset_pulse` is high for exactly one master-clock cycle. It rises on the third rising edge of `clk` after `sclk` falls to end a valid third pulse (two synchronizer stages plus one registered stage).
- R6: While `cs_n` is 1, `sclk` is ignored, no pulse is produced, and a partly seen pattern is discarded. Level measurement restarts when `cs_n` returns to 0.
- R7: If a high level fails the window for the second or third pulse but fits the first-pulse window, it is taken as a new first pulse.
- R8: The level counter saturates above the largest window limit. A high level far longer than 2400 cycles, including one of 4696 cycles whose low bits would alias into the first window, is never accepted.
- R9: After a reset pulse the detector is idle. A second and a third pulse alone do not fire it again; a full three-pulse pattern is needed.
- R10: Ordinary serial clocking (short highs and lows of a few cycles) never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all measurement is in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset of the detector state |
| sclk | input | 1 | Serial clock line, asynchronous to `clk` |
| cs_n | input | 1 | Active-low chip-select; detection only while 0 |
| reset_pulse | output | 1 | One-cycle internal reset request |

## Verification
Every window edge is tried with lengths one cycle inside and one cycle outside its limits. This separates an inclusive comparison from an exclusive one, and shows whether each stage uses its own limits. A nominal pattern is sampled cycle by cycle around the closing falling edge to pin the three-stage latency and the one-cycle width. Further patterns isolate behaviours that a plain pass/fail pattern would hide: a failed second pulse that fits the first window, chip-select raised mid-pattern, a 4696-cycle high that a wrapping counter would misread as 600, a tail without a first pulse right after a firing, and bursts of short serial clocking.

// File: rtl/rstpat_pkg.sv
package rstpat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_GAP1 = 3'd1,
        ST_HI2  = 3'd2,
        ST_GAP2 = 3'd3,
        ST_HI3  = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   pulse;
    } seq_t;

endpackage

// File: rtl/rstpat_sync.sv
module rstpat_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rstpat_runlen.sv
module rstpat_runlen #(
    parameter int CNT_W = 12,
    parameter int SAT   = 2401
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             lvl_in,
    output logic             lvl_q,
    output logic             rise,
    output logic             fall,
    output logic [CNT_W-1:0] run
);
    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } rl_t;

    rl_t cur_q, cur_d;
    logic edge_w;

    assign edge_w = lvl_in ^ cur_q.lvl;

    always_comb begin
        cur_d     = cur_q;
        cur_d.lvl = lvl_in;
        if (hold) begin
            cur_d.cnt = '0;
        end else if (edge_w) begin
            cur_d.cnt = CNT_W'(1);
        end else if (cur_q.cnt != SAT_V) begin
            cur_d.cnt = cur_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign lvl_q = cur_q.lvl;
    assign rise  = edge_w & lvl_in;
    assign fall  = edge_w & ~lvl_in;
    assign run   = cur_q.cnt;
endmodule

// File: rtl/rstpat_window.sv
module rstpat_window #(
    parameter int CNT_W = 12,
    parameter int LO    = 1,
    parameter int HI    = 1
) (
    input  logic [CNT_W-1:0] len,
    output logic             hit
);
    localparam logic [CNT_W-1:0] LO_V = CNT_W'(LO);
    localparam logic [CNT_W-1:0] HI_V = CNT_W'(HI);

    assign hit = (len >= LO_V) && (len <= HI_V);
endmodule

// File: rtl/rstpat_detect.sv
module rstpat_detect #(
    parameter int SYNC_STAGES = 2,
    parameter int H1_MIN = 512,
    parameter int H1_MAX = 800,
    parameter int GAP_MIN = 10,
    parameter int H2_MIN = 1024,
    parameter int H2_MAX = 1800,
    parameter int H3_MIN = 2048,
    parameter int H3_MAX = 2400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic reset_pulse
);
    import rstpat_pkg::*;

    localparam int TOP_MAX = (H3_MAX > H2_MAX) ? ((H3_MAX > H1_MAX) ? H3_MAX : H1_MAX)
                                               : ((H2_MAX > H1_MAX) ? H2_MAX : H1_MAX);
    localparam int SAT_C   = TOP_MAX + 1;
    localparam int CNT_W   = $clog2(SAT_C + 1);

    logic             sclk_s;
    logic             lvl_w;
    logic             rise_w, fall_w;
    logic [CNT_W-1:0] run_w;
    logic             win1, win2, win3, gap_ok;

    rstpat_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(sclk), .dout(sclk_s)
    );

    rstpat_runlen #(.CNT_W(CNT_W), .SAT(SAT_C)) u_run (
        .clk(clk), .rst_n(rst_n), .hold(cs_n), .lvl_in(sclk_s),
        .lvl_q(lvl_w), .rise(rise_w), .fall(fall_w), .run(run_w)
    );

    rstpat_window #(.CNT_W(CNT_W), .LO(H1_MIN), .HI(H1_MAX)) u_w1 (.len(run_w), .hit(win1));
    rstpat_window #(.CNT_W(CNT_W), .LO(H2_MIN), .HI(H2_MAX)) u_w2 (.len(run_w), .hit(win2));
    rstpat_window #(.CNT_W(CNT_W), .LO(H3_MIN), .HI(H3_MAX)) u_w3 (.len(run_w), .hit(win3));
    rstpat_window #(.CNT_W(CNT_W), .LO(GAP_MIN), .HI(SAT_C)) u_wg (.len(run_w), .hit(gap_ok));

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d       = seq_q;
        seq_d.pulse = 1'b0;
        if (cs_n) begin
            seq_d.phase = ST_IDLE;
        end else begin
            unique case (seq_q.phase)
                ST_IDLE: begin
                    if (fall_w && win1) seq_d.phase = ST_GAP1;
                end
                ST_GAP1: begin
                    if (rise_w) seq_d.phase = gap_ok ? ST_HI2 : ST_IDLE;
                end
                ST_HI2: begin
                    if (fall_w) begin
                        if (win2)      seq_d.phase = ST_GAP2;
                        else if (win1) seq_d.phase = ST_GAP1;
                        else           seq_d.phase = ST_IDLE;
                    end
                end
                ST_GAP2: begin
                    if (rise_w) seq_d.phase = gap_ok ? ST_HI3 : ST_IDLE;
                end
                ST_HI3: begin
                    if (fall_w) begin
                        if (win3) begin
                            seq_d.phase = ST_IDLE;
                            seq_d.pulse = 1'b1;
                        end else if (win1) begin
                            seq_d.phase = ST_GAP1;
                        end else begin
                            seq_d.phase = ST_IDLE;
                        end
                    end
                end
                default: seq_d.phase = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: ST_IDLE, pulse: 1'b0};
        else        seq_q <= seq_d;
    end

    assign reset_pulse = seq_q.pulse;
endmodule

// File: rtl/rstpat_detect_chk.sv
module rstpat_detect_chk #(
    parameter int CNT_W  = 12,
    parameter int SAT    = 2401,
    parameter int H1_MIN = 512,
    parameter int H1_MAX = 800
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               reset_pulse,
    input logic               lvl_q,
    input logic [CNT_W-1:0]   run,
    input rstpat_pkg::phase_e phase
);
    import rstpat_pkg::*;

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse);

    // R5
    pulse_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> (!lvl_q && $past(lvl_q)));

    // R6
    cs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !reset_pulse);

    // R9
    idle_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> (phase == ST_IDLE));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run <= CNT_W'(SAT));

    // R1
    first_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_GAP1 && $past(phase) == ST_IDLE) |->
            ($past(run) >= CNT_W'(H1_MIN) && $past(run) <= CNT_W'(H1_MAX)));
endmodule

bind rstpat_detect rstpat_detect_chk #(
    .CNT_W(CNT_W), .SAT(SAT_C), .H1_MIN(H1_MIN), .H1_MAX(H1_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .reset_pulse(reset_pulse),
    .lvl_q(lvl_w), .run(run_w), .phase(seq_q.phase)
);

// File: tb/rstpat_detect_bench.sv
module rstpat_detect_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic reset_pulse;

    int n_vec = 0;
    int n_bad = 0;
    int pulses = 0;
    int base = 0;
    bit done = 1'b0;

    int    exp_q[$];
    string tag_q[$];
    event  chk_ev;

    always #2 clk = ~clk;

    rstpat_detect u_rstpat_detect (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .reset_pulse(reset_pulse)
    );

    always @(negedge clk) if (rst_n && reset_pulse) pulses++;

    // scoreboard monitor
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                automatic int    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                automatic int    got = pulses - base;
                base = pulses;
                n_vec++;
                if (got != e) begin
                    n_bad++;
                    $display("FAIL %s: pulses actual %0d expected %0d", t, got, e);
                end
            end
        end
    end

    task automatic hi(input int n);
        sclk = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic lo(input int n);
        sclk = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pulses(input int e, input string t);
        lo(12);
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> chk_ev;
        @(negedge clk);
    endtask

    task automatic pat(input int h1, input int g1, input int h2, input int g2,
                       input int h3, input int e, input string t);
        lo(20);
        hi(h1); lo(g1); hi(h2); lo(g2); hi(h3);
        expect_pulses(e, t);
    endtask

    task automatic direct(input logic got, input logic e, input string t);
        n_vec++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", t, got, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        direct(reset_pulse, 1'b0, "reset state R5");
        rst_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        lo(20);
        direct(reset_pulse, 1'b0, "idle after reset R5");

        // R5 exact latency and width
        hi(600); lo(20); hi(1400); lo(20); hi(2200);
        sclk = 1'b0;
        @(negedge clk); direct(reset_pulse, 1'b0, "R5 latency cycle 1");
        @(negedge clk); direct(reset_pulse, 1'b0, "R5 latency cycle 2");
        @(negedge clk); direct(reset_pulse, 1'b1, "R5 pulse cycle 3");
        @(negedge clk); direct(reset_pulse, 1'b0, "R5 single cycle");
        expect_pulses(1, "R5 nominal pattern count");

        pat(512, 10, 1024, 10, 2048, 1, "R1 R2 R3 R4 lower limits");
        pat(800, 10, 1800, 10, 2400, 1, "R1 R3 R4 upper limits");
        pat(511, 20, 1400, 20, 2200, 0, "R1 first too short");
        pat(801, 20, 1400, 20, 2200, 0, "R1 first too long");
        pat(600, 9, 1400, 20, 2200, 0, "R2 first gap short");
        pat(600, 20, 1400, 9, 2200, 0, "R2 second gap short");
        pat(600, 20, 1023, 20, 2200, 0, "R3 second too short");
        pat(600, 20, 1801, 20, 2200, 0, "R3 second too long");
        pat(600, 20, 1400, 20, 2047, 0, "R4 third too short");
        pat(600, 20, 1400, 20, 2401, 0, "R4 third too long");

        // R6: chip-select high for the whole pattern
        cs_n = 1'b1;
        pat(600, 20, 1400, 20, 2200, 0, "R6 cs high whole pattern");
        cs_n = 1'b0;
        // R6: chip-select raised during the second pulse
        lo(20); hi(600); lo(20); hi(700); cs_n = 1'b1; hi(700); cs_n = 1'b0;
        lo(20); hi(2200);
        expect_pulses(0, "R6 cs high mid pattern");

        // R7: failed second pulse fits first window and restarts
        lo(20); hi(600); lo(20); hi(700); lo(20); hi(1400); lo(20); hi(2200);
        expect_pulses(1, "R7 re-evaluated first pulse");

        // R8: very long high aliasing to 600 on a wrapping counter
        lo(20); hi(4696); lo(20); hi(1400); lo(20); hi(2200);
        expect_pulses(0, "R8 saturating counter");

        // R9: fire, then tail only
        pat(600, 20, 1400, 20, 2200, 1, "R9 first firing");
        lo(20); hi(1400); lo(20); hi(2200);
        expect_pulses(0, "R9 tail alone");

        // R10: ordinary serial clocking
        lo(20);
        for (int i = 0; i < 80; i++) begin
            hi(5); lo(5);
        end
        expect_pulses(0, "R10 short clocking");

        lo(20);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule